// File: doc/BRIEF.md
# 16x16 Intra DC Predictor

This block forms the flat (DC) prediction for one 16x16 luma block. A start pulse captures two availability flags, one for the row of samples above the block and one for the column to its left. Neighbour samples then arrive one per handshake on a small input stream. Each sample carries a side tag that says whether it belongs to the row above or the column to the left. The block adds up the samples of each available side and forms one rounded mean. It then sends that value 256 times as a 16x16 block in raster order on an output stream.

Both streams use valid/ready. A beat moves on a rising clock edge where valid and ready are both high. The input ready is driven from the block's state alone. It is high only while samples are still being gathered, so a source may keep valid high and simply wait. On the output side, the block keeps valid, data and last unchanged for as long as the sink holds ready low, and it never withdraws a beat it has offered. The start and done pins are plain single-cycle pulses.

Top module: `intra_dc_pred_top`

## Requirements
- R1: After reset, `nbr_ready`, `blk_valid` and `done` are all low.
- R2: A `start` pulse in the idle state latches `above_avail` and `left_avail` and clears both sums. While gathering, `nbr_ready` is high. Gathering ends once 16 samples have been taken for every available side, and `nbr_ready` and `blk_valid` are never high together.
- R3: With neither side available, no samples are taken (`nbr_ready` stays low) and every output sample is 128.
- R4: With exactly one side available, the value is (sum of that side's 16 samples + 8) >> 4.
- R5: With both sides available, the value is (sum of all 32 samples + 16) >> 5, computed with no overflow even when every sample is 255.
- R6: The side tag `nbr_is_left` is 0 for the row above and 1 for the left column. A sample tagged for an unavailable side is accepted and discarded. So is any sample beyond the 16th for a side.
- R7: The output block has 256 samples, all equal to the DC value. `blk_last` is high on the 256th sample only.
- R8: While `blk_valid` is high and `blk_ready` is low, `blk_valid`, `blk_data` and `blk_last` hold their values into the next cycle.
- R9: `done` is high for exactly one cycle, in the cycle after the edge that accepts the last output sample. The block is then idle again.
- R10: A `start` pulse outside the idle state has no effect: the flags in use and the result do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new block (taken only when idle) |
| above_avail | input | 1 | Row above may be used; sampled with start |
| left_avail | input | 1 | Left column may be used; sampled with start |
| nbr_valid | input | 1 | Neighbour sample offered |
| nbr_ready | output | 1 | Block takes neighbour samples |
| nbr_is_left | input | 1 | Side tag: 0 above, 1 left |
| nbr_sample | input | 8 | Neighbour sample value |
| blk_valid | output | 1 | Output sample offered |
| blk_ready | input | 1 | Sink takes the output sample |
| blk_data | output | 8 | Predicted sample (the DC value) |
| blk_last | output | 1 | Marks sample 255 of the block |
| done | output | 1 | One-cycle pulse after the block has been sent |

## Verification
The bench drives every sample at 255 with both sides available. A sum that is too narrow would wrap there and give a small value instead of 255. It also sets up one-side cases that sit right at a rounding boundary (sums of 23 and 24), where a wrong rounding constant or shift moves the result by one. It mixes in samples tagged for an unavailable side, extra samples past the 16th, and start pulses in the middle of a block. A design that let any of these through would show a shifted mean, different flags, or a gather phase that ends too early or never. Random back-pressure on the output checks that data and last are held. It also checks that last lands on exactly sample 256 and that done appears one cycle after that beat.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GATHER = 2'd1,
    ST_CALC   = 2'd2,
    ST_EMIT   = 2'd3
  } dcp_state_e;

  localparam int SIDE_ABOVE = 0;
  localparam int SIDE_LEFT  = 1;
  localparam int NUM_SIDES  = 2;

endpackage

// File: rtl/dcp_side_acc.sv
module dcp_side_acc #(
  parameter int SAMPLE_W = 8,
  parameter int BLK_DIM  = 16,
  localparam int SUM_W   = SAMPLE_W + $clog2(BLK_DIM),
  localparam int CNT_W   = $clog2(BLK_DIM + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                enable,
  input  logic                take,
  input  logic [SAMPLE_W-1:0] sample,
  output logic [SUM_W-1:0]    sum,
  output logic                full
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(BLK_DIM);

  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] sum_q;

  // count only the first BLK_DIM samples of an enabled side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sum_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
      sum_q <= '0;
    end else if (take && enable && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
      sum_q <= sum_q + SUM_W'(sample);
    end
  end

  assign sum  = sum_q;
  assign full = !enable || (cnt_q == CNT_MAX);

endmodule

// File: rtl/dcp_mean_calc.sv
module dcp_mean_calc #(
  parameter int SAMPLE_W = 8,
  parameter int BLK_DIM  = 16,
  localparam int SUM_W   = SAMPLE_W + $clog2(BLK_DIM),
  localparam int ACC_W   = SUM_W + 1,
  localparam int SH_ONE  = $clog2(BLK_DIM),
  localparam int SH_TWO  = SH_ONE + 1
) (
  input  logic                above_en,
  input  logic                left_en,
  input  logic [SUM_W-1:0]    above_sum,
  input  logic [SUM_W-1:0]    left_sum,
  output logic [SAMPLE_W-1:0] dc
);

  localparam logic [ACC_W-1:0]    RND_ONE  = ACC_W'(1) << (SH_ONE - 1);
  localparam logic [ACC_W-1:0]    RND_TWO  = ACC_W'(1) << (SH_TWO - 1);
  localparam logic [SAMPLE_W-1:0] FALLBACK = SAMPLE_W'(1) << (SAMPLE_W - 1);

  logic [ACC_W-1:0] total;
  logic [ACC_W-1:0] scaled;

  // a disabled side never accumulates, so its sum stays zero
  assign total = ACC_W'(above_sum) + ACC_W'(left_sum);

  always_comb begin
    scaled = '0;
    dc     = FALLBACK;
    if (above_en && left_en) begin
      scaled = (total + RND_TWO) >> SH_TWO;
      dc     = scaled[SAMPLE_W-1:0];
    end else if (above_en || left_en) begin
      scaled = (total + RND_ONE) >> SH_ONE;
      dc     = scaled[SAMPLE_W-1:0];
    end
  end

endmodule

// File: rtl/dcp_raster_out.sv
module dcp_raster_out #(
  parameter int SAMPLE_W = 8,
  parameter int BLK_DIM  = 16,
  localparam int NUM_PIX = BLK_DIM * BLK_DIM,
  localparam int IDX_W   = $clog2(NUM_PIX)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [SAMPLE_W-1:0] dc_in,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_data,
  output logic                out_last,
  output logic                fin
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PIX - 1);

  logic                active_q;
  logic [IDX_W-1:0]    idx_q;
  logic [SAMPLE_W-1:0] data_q;
  logic                beat;

  assign beat = active_q && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      data_q   <= '0;
    end else if (load) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      data_q   <= dc_in;
    end else if (beat) begin
      if (idx_q == LAST_IDX) active_q <= 1'b0;
      else                   idx_q    <= idx_q + 1'b1;
    end
  end

  assign out_valid = active_q;
  assign out_data  = data_q;
  assign out_last  = active_q && (idx_q == LAST_IDX);
  assign fin       = beat && (idx_q == LAST_IDX);

endmodule

// File: rtl/intra_dc_pred_top.sv
module intra_dc_pred_top #(
  parameter int SAMPLE_W = 8,
  parameter int BLK_DIM  = 16,
  localparam int SUM_W   = SAMPLE_W + $clog2(BLK_DIM)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                above_avail,
  input  logic                left_avail,
  input  logic                nbr_valid,
  output logic                nbr_ready,
  input  logic                nbr_is_left,
  input  logic [SAMPLE_W-1:0] nbr_sample,
  output logic                blk_valid,
  input  logic                blk_ready,
  output logic [SAMPLE_W-1:0] blk_data,
  output logic                blk_last,
  output logic                done
);
  import dcp_pkg::*;

  dcp_state_e state_q, state_d;

  logic [NUM_SIDES-1:0] side_en_q;
  logic [NUM_SIDES-1:0] side_full;
  logic [SUM_W-1:0]     side_sum [NUM_SIDES];
  logic                 clr;
  logic                 nbr_beat;
  logic                 load;
  logic                 fin;
  logic                 done_q;
  logic [SAMPLE_W-1:0]  dc_val;

  assign clr       = (state_q == ST_IDLE) && start;
  assign nbr_ready = (state_q == ST_GATHER) && !(&side_full);
  assign nbr_beat  = nbr_valid && nbr_ready;
  assign load      = (state_q == ST_CALC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   side_en_q <= '0;
    else if (clr) side_en_q <= {left_avail, above_avail};
  end

  for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
    logic take;
    assign take = nbr_beat && (nbr_is_left == 1'(g));
    dcp_side_acc #(
      .SAMPLE_W(SAMPLE_W),
      .BLK_DIM (BLK_DIM)
    ) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .enable(side_en_q[g]),
      .take  (take),
      .sample(nbr_sample),
      .sum   (side_sum[g]),
      .full  (side_full[g])
    );
  end

  dcp_mean_calc #(
    .SAMPLE_W(SAMPLE_W),
    .BLK_DIM (BLK_DIM)
  ) u_mean (
    .above_en (side_en_q[SIDE_ABOVE]),
    .left_en  (side_en_q[SIDE_LEFT]),
    .above_sum(side_sum[SIDE_ABOVE]),
    .left_sum (side_sum[SIDE_LEFT]),
    .dc       (dc_val)
  );

  dcp_raster_out #(
    .SAMPLE_W(SAMPLE_W),
    .BLK_DIM (BLK_DIM)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .dc_in    (dc_val),
    .out_ready(blk_ready),
    .out_valid(blk_valid),
    .out_data (blk_data),
    .out_last (blk_last),
    .fin      (fin)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) state_d = (above_avail || left_avail) ? ST_GATHER : ST_CALC;
      end
      ST_GATHER: begin
        if (&side_full) state_d = ST_CALC;
      end
      ST_CALC: state_d = ST_EMIT;
      ST_EMIT: begin
        if (fin) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
    end
  end

  assign done = done_q;

endmodule

// File: rtl/dcp_checker.sv
module dcp_checker #(
  parameter int SAMPLE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                nbr_ready,
  input logic                blk_valid,
  input logic                blk_ready,
  input logic [SAMPLE_W-1:0] blk_data,
  input logic                blk_last,
  input logic                done
);

  // R8
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && !blk_ready |=> blk_valid && $stable(blk_data) && $stable(blk_last));

  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(blk_valid && blk_ready && blk_last));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  last_in_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_last |-> blk_valid);

  // R2
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nbr_ready && blk_valid));

endmodule

bind intra_dc_pred_top dcp_checker #(.SAMPLE_W(SAMPLE_W)) u_dcp_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .nbr_ready(nbr_ready),
  .blk_valid(blk_valid),
  .blk_ready(blk_ready),
  .blk_data (blk_data),
  .blk_last (blk_last),
  .done     (done)
);

// File: tb/intra_dc_pred_top_tb_top.sv
`timescale 1ns/1ps
module intra_dc_pred_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       above_avail = 1'b0;
  logic       left_avail = 1'b0;
  logic       nbr_valid = 1'b0;
  logic       nbr_ready;
  logic       nbr_is_left = 1'b0;
  logic [7:0] nbr_sample = '0;
  logic       blk_valid;
  logic       blk_ready = 1'b0;
  logic [7:0] blk_data;
  logic       blk_last;
  logic       done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0] above_s [16];
  logic [7:0] left_s  [16];
  logic       it_side [64];
  logic [7:0] it_val  [64];

  always #2.5 clk = ~clk;

  intra_dc_pred_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .above_avail(above_avail), .left_avail(left_avail),
    .nbr_valid(nbr_valid), .nbr_ready(nbr_ready),
    .nbr_is_left(nbr_is_left), .nbr_sample(nbr_sample),
    .blk_valid(blk_valid), .blk_ready(blk_ready),
    .blk_data(blk_data), .blk_last(blk_last), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_dc(input bit au, input bit al);
    int sa = 0, sl = 0;
    for (int i = 0; i < 16; i++) begin
      sa += above_s[i];
      sl += left_s[i];
    end
    if (au && al) return (sa + sl + 16) >> 5;
    if (au)       return (sa + 8) >> 4;
    if (al)       return (sl + 8) >> 4;
    return 128;
  endfunction

  task automatic run_case(input bit au, input bit al, input int stall_pct,
                          input bit junk, input bit extra, input bit poke);
    int    n = 0;
    int    idx;
    int    cnt;
    int    expv;
    bit    held;
    logic [7:0] held_v;
    string req;
    expv = exp_dc(au, al);
    req  = (au && al) ? "R5" : ((au || al) ? "R4" : "R3");
    // unavailable side junk first (R6), then real samples
    if (junk && (au || al)) begin
      for (int i = 0; i < 4; i++) begin
        if (!au) begin it_side[n] = 1'b0; it_val[n] = 8'($urandom); n++; end
        if (!al) begin it_side[n] = 1'b1; it_val[n] = 8'($urandom); n++; end
      end
    end
    if (au) for (int i = 0; i < 16; i++) begin it_side[n] = 1'b0; it_val[n] = above_s[i]; n++; end
    if (extra && au && al) for (int i = 0; i < 3; i++) begin
      it_side[n] = 1'b0; it_val[n] = 8'hFF; n++;
    end
    if (al) for (int i = 0; i < 16; i++) begin it_side[n] = 1'b1; it_val[n] = left_s[i]; n++; end

    @(negedge clk);
    start = 1'b1; above_avail = au; left_avail = al;
    @(negedge clk);
    start = 1'b0;
    if (!au && !al) begin
      for (int k = 0; k < 2; k++) begin
        chk(nbr_ready == 1'b0, "R3 nbr_ready", int'(nbr_ready), 0);
        if (k == 0) @(negedge clk);
      end
    end
    idx = 0;
    while (idx < n) begin
      nbr_valid   = ($urandom % 100) >= 20;
      nbr_is_left = it_side[idx];
      nbr_sample  = it_val[idx];
      start       = poke && (idx == 3);
      above_avail = start ? ~au : au;
      left_avail  = start ? ~al : al;
      if (nbr_valid && nbr_ready) idx++;
      @(negedge clk);
    end
    nbr_valid = 1'b0; start = 1'b0; above_avail = au; left_avail = al;

    cnt = 0; held = 0; held_v = '0;
    while (cnt < 256) begin
      blk_ready = ($urandom % 100) >= stall_pct;
      start = poke && (cnt == 100);
      if (held) begin
        chk(blk_valid && blk_data == held_v, "R8 hold", int'(blk_data), int'(held_v));
      end
      if (blk_valid) begin
        chk(int'(blk_data) == expv, req, int'(blk_data), expv);
        chk(blk_last == (cnt == 255), "R7 last", int'(blk_last), int'(cnt == 255));
        if (blk_ready) begin cnt++; held = 0; end
        else begin held = 1; held_v = blk_data; end
      end
      @(negedge clk);
    end
    blk_ready = 1'b0; start = 1'b0;
    chk(done == 1'b1, "R9 done high", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0, "R9 done single", int'(done), 0);
    chk(blk_valid == 1'b0, "R9 idle", int'(blk_valid), 0);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0d1c));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(nbr_ready == 0, "R1 nbr_ready", int'(nbr_ready), 0);
    chk(blk_valid == 0, "R1 blk_valid", int'(blk_valid), 0);
    chk(done == 0, "R1 done", int'(done), 0);

    // R5 max values, no overflow
    for (int i = 0; i < 16; i++) begin above_s[i] = 8'hFF; left_s[i] = 8'hFF; end
    run_case(1, 1, 0, 0, 0, 0);
    // R3 neither side
    run_case(0, 0, 30, 0, 0, 0);
    // R4 rounding boundary: 24 -> 2, 23 -> 1
    for (int i = 0; i < 16; i++) begin above_s[i] = 0; left_s[i] = 8'hAA; end
    above_s[0] = 8'd24;
    run_case(1, 0, 20, 1, 0, 0);
    above_s[0] = 8'd23;
    run_case(1, 0, 0, 1, 0, 0);
    // R4 left only with junk on the above side (R6)
    for (int i = 0; i < 16; i++) left_s[i] = 8'(i * 13 + 7);
    run_case(0, 1, 40, 1, 0, 0);
    // R6 extra samples beyond 16, R10 start pokes
    for (int i = 0; i < 16; i++) begin above_s[i] = 8'(i); left_s[i] = 8'(200 - i); end
    run_case(1, 1, 25, 0, 1, 1);
    run_case(1, 0, 25, 1, 0, 1);
    // random mix
    for (int t = 0; t < 10; t++) begin
      for (int i = 0; i < 16; i++) begin above_s[i] = 8'($urandom); left_s[i] = 8'($urandom); end
      run_case(1'($urandom), 1'($urandom), int'($urandom % 50), 1'($urandom),
               1'($urandom), 1'($urandom));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule